// File: doc/BRIEF.md
# Adder-Subtractor-Compare Unit with Status Flags

This block is the integer arithmetic slice of a processor datapath. It takes two operands, a two-bit function code and a signed/unsigned mode bit, and produces either the sum, the difference, or a zero-extended one-bit "less than" verdict. It also produces a four-bit status vector describing that outcome. All three operations run through one carry-lookahead adder. Subtraction and comparison add the inverted second operand with the carry-in set.

The adder is built from fixed-width groups. Each group computes its own generate and propagate terms, and a second lookahead level turns these group terms into the carry into every group. The result and status are captured in registers on the rising clock edge. Capture happens only when the enable input is high and the function code names a real operation. Otherwise the previous outputs are held. Operand width and group width are parameters. The defaults are 32 bits in groups of 4.

Top module: `asc_unit`

## Requirements
- R1: With `en` high and `func` = 2'b00 (add), the `result` after the next rising edge is (a + b) mod 2^WIDTH, and status bit 3 (carry) is the carry-out of that addition.
- R2: With `en` high and `func` = 2'b01 (subtract), the `result` after the next rising edge is (a - b) mod 2^WIDTH, computed as a + ~b + 1, and status bit 3 is the raw carry-out of that sum (1 exactly when a >= b unsigned).
- R3: Status bit 2 (overflow) is set in signed mode only when both adder inputs (a, and b or ~b) have the same sign bit and the sum's sign bit differs from it; in unsigned mode (`signed_op` low) it is always 0.
- R4: Status bit 1 (zero) is 1 exactly when the registered `result` is all zeros, and status bit 0 (negative) equals the top bit of the registered `result`.
- R5: With `func` = 2'b10 (set-less-than) and `signed_op` high, `result` is 1 when a < b as two's-complement numbers (negative XOR overflow of a - b), else 0, with bits WIDTH-1..1 always 0.
- R6: With `func` = 2'b10 and `signed_op` low, `result` is 1 when a < b as unsigned numbers (a - b gives no carry-out), else 0, with the upper bits 0.
- R7: For set-less-than, status bits 3 and 2 are the carry and overflow of a - b (overflow only in signed mode), and bits 1 and 0 describe the 0/1 result.
- R8: While `en` is low, `result` and `status` keep their values whatever the other inputs do.
- R9: The function code 2'b11 is reserved: with `en` high it leaves `result` and `status` unchanged.
- R10: While `rst_n` is low, `result` is 0 and `status` is 4'b0010 (only the zero flag set).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; outputs update on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Capture enable for result and status |
| func | input | 2 | Operation: 00 add, 01 subtract, 10 set-less-than, 11 reserved |
| signed_op | input | 1 | 1 selects two's-complement treatment, 0 unsigned |
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| result | output | WIDTH | Registered result |
| status | output | 4 | Registered flags: bit 3 carry, bit 2 overflow, bit 1 zero, bit 0 negative |

## Verification
A wrong group generate or propagate term, or a wrong second-level carry, appears one cycle after the enabled edge. It shows as a wrong result bit at a group boundary and usually a wrong carry flag. Only some operand pairs show it, so the bench sweeps every second operand against a dense set of first operands, in a narrow configuration that still has two groups. A wrong overflow rule shows within one cycle in signed mode as a flipped overflow flag. In set-less-than it also shows as an inverted verdict. A bad update condition appears as outputs that change during idle or reserved cycles, and these cycles are probed directly.

// File: rtl/asc_pkg.sv
package asc_pkg;

  typedef enum logic [1:0] {
    FN_ADD = 2'b00,
    FN_SUB = 2'b01,
    FN_SLT = 2'b10,
    FN_RSV = 2'b11
  } asc_func_e;

  // bit positions in the status vector
  localparam int ST_C = 3;
  localparam int ST_V = 2;
  localparam int ST_Z = 1;
  localparam int ST_N = 0;

  localparam logic [3:0] ST_RESET = 4'b0010;

  // overflow from the sign bits that enter and leave the adder
  function automatic logic sign_overflow(input logic x_msb, input logic y_msb,
                                         input logic s_msb, input logic signed_mode);
    return signed_mode & (x_msb ~^ y_msb) & (s_msb ^ x_msb);
  endfunction

  // less-than verdict drawn from the flags of a - b
  function automatic logic below(input logic signed_mode, input logic neg,
                                 input logic ovf, input logic cout);
    return signed_mode ? (neg ^ ovf) : ~cout;
  endfunction

endpackage

// File: rtl/asc_cla_group.sv
module asc_cla_group #(
  parameter int GW = 4
) (
  input  logic [GW-1:0] x,
  input  logic [GW-1:0] y,
  input  logic          cin,
  output logic [GW-1:0] sum,
  output logic          grp_g,
  output logic          grp_p
);

  logic [GW-1:0] gen;
  logic [GW-1:0] prop;
  logic [GW:0]   cy;

  // carry into bit idx, written as a flat sum of products
  function automatic logic carry_at(input logic [GW-1:0] gv, input logic [GW-1:0] pv,
                                    input logic ci, input int idx);
    logic acc;
    logic run;
    acc = 1'b0;
    for (int k = 0; k < GW; k++) begin
      if (k < idx) begin
        run = gv[k];
        for (int m = 0; m < GW; m++)
          if (m > k && m < idx) run = run & pv[m];
        acc = acc | run;
      end
    end
    run = ci;
    for (int m = 0; m < GW; m++)
      if (m < idx) run = run & pv[m];
    return acc | run;
  endfunction

  assign gen  = x & y;
  assign prop = x ^ y;

  always_comb begin
    for (int i = 0; i <= GW; i++) cy[i] = carry_at(gen, prop, cin, i);
  end

  assign sum   = prop ^ cy[GW-1:0];
  assign grp_g = carry_at(gen, prop, 1'b0, GW);
  assign grp_p = &prop;

endmodule

// File: rtl/asc_cla_carry.sv
module asc_cla_carry #(
  parameter int NG = 8
) (
  input  logic [NG-1:0] gg,
  input  logic [NG-1:0] gp,
  input  logic          cin,
  output logic [NG:0]   cy
);

  function automatic logic carry_at(input logic [NG-1:0] gv, input logic [NG-1:0] pv,
                                    input logic ci, input int idx);
    logic acc;
    logic run;
    acc = 1'b0;
    for (int k = 0; k < NG; k++) begin
      if (k < idx) begin
        run = gv[k];
        for (int m = 0; m < NG; m++)
          if (m > k && m < idx) run = run & pv[m];
        acc = acc | run;
      end
    end
    run = ci;
    for (int m = 0; m < NG; m++)
      if (m < idx) run = run & pv[m];
    return acc | run;
  endfunction

  always_comb begin
    for (int j = 0; j <= NG; j++) cy[j] = carry_at(gg, gp, cin, j);
  end

endmodule

// File: rtl/asc_cla_adder.sv
module asc_cla_adder #(
  parameter int WIDTH = 32,
  parameter int GW    = 4   // WIDTH must be a multiple of GW
) (
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);

  localparam int NG = WIDTH / GW;

  logic [NG-1:0] grp_g;
  logic [NG-1:0] grp_p;
  logic [NG:0]   grp_c;

  for (genvar j = 0; j < NG; j++) begin : g_grp
    asc_cla_group #(.GW(GW)) u_grp (
      .x     (x[j*GW +: GW]),
      .y     (y[j*GW +: GW]),
      .cin   (grp_c[j]),
      .sum   (sum[j*GW +: GW]),
      .grp_g (grp_g[j]),
      .grp_p (grp_p[j])
    );
  end

  asc_cla_carry #(.NG(NG)) u_carry (
    .gg  (grp_g),
    .gp  (grp_p),
    .cin (cin),
    .cy  (grp_c)
  );

  assign cout = grp_c[NG];

endmodule

// File: rtl/asc_outcome.sv
module asc_outcome
  import asc_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [1:0]       func,
  input  logic             signed_op,
  input  logic             x_msb,
  input  logic             y_msb,
  input  logic [WIDTH-1:0] sum,
  input  logic             cout,
  output logic [WIDTH-1:0] nxt_result,
  output logic [3:0]       nxt_status,
  output logic             ovf_raw,
  output logic             lt_raw
);

  assign ovf_raw = sign_overflow(x_msb, y_msb, sum[WIDTH-1], signed_op);
  assign lt_raw  = below(signed_op, sum[WIDTH-1], ovf_raw, cout);

  always_comb begin
    if (func == FN_SLT) nxt_result = {{(WIDTH-1){1'b0}}, lt_raw};
    else                nxt_result = sum;
    nxt_status       = '0;
    nxt_status[ST_C] = cout;
    nxt_status[ST_V] = ovf_raw;
    nxt_status[ST_Z] = (nxt_result == '0);
    nxt_status[ST_N] = nxt_result[WIDTH-1];
  end

endmodule

// File: rtl/asc_unit.sv
module asc_unit
  import asc_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int GW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [1:0]       func,
  input  logic             signed_op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] result,
  output logic [3:0]       status
);

  logic             invert_b;
  logic [WIDTH-1:0] op_y;
  logic [WIDTH-1:0] sum_raw;
  logic             cout_raw;
  logic             ovf_raw;
  logic             lt_raw;
  logic [WIDTH-1:0] nxt_result;
  logic [3:0]       nxt_status;
  logic             upd;

  assign invert_b = (func != FN_ADD);
  assign op_y     = invert_b ? ~b : b;
  assign upd      = en && (func != FN_RSV);

  asc_cla_adder #(.WIDTH(WIDTH), .GW(GW)) u_adder (
    .x    (a),
    .y    (op_y),
    .cin  (invert_b),
    .sum  (sum_raw),
    .cout (cout_raw)
  );

  asc_outcome #(.WIDTH(WIDTH)) u_outcome (
    .func       (func),
    .signed_op  (signed_op),
    .x_msb      (a[WIDTH-1]),
    .y_msb      (op_y[WIDTH-1]),
    .sum        (sum_raw),
    .cout       (cout_raw),
    .nxt_result (nxt_result),
    .nxt_status (nxt_status),
    .ovf_raw    (ovf_raw),
    .lt_raw     (lt_raw)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
      status <= ST_RESET;
    end else if (upd) begin
      result <= nxt_result;
      status <= nxt_status;
    end
  end

endmodule

// File: rtl/asc_unit_chk.sv
module asc_unit_chk
  import asc_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic [1:0]       func,
  input logic             signed_op,
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic [WIDTH-1:0] result,
  input logic [3:0]       status,
  input logic             cout_raw
);

  AST_ADD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && func == FN_ADD) |=> (result == $past(a) + $past(b))); // R1
  AST_ADD_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (en && func == FN_ADD) |=> (status[ST_C] == $past(cout_raw))); // R1
  AST_SUB_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && func == FN_SUB) |=> (result == $past(a) - $past(b))); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !signed_op && func != FN_RSV) |=> !status[ST_V]); // R3
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    status[ST_Z] == (result == '0)); // R4
  AST_NEG_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    status[ST_N] == result[WIDTH-1]); // R4
  AST_SLT_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (en && func == FN_SLT) |=> (result[WIDTH-1:1] == '0)); // R5
  AST_SLT_UNSIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (en && func == FN_SLT && !signed_op) |=> (result[0] == ($past(a) < $past(b)))); // R6
  AST_SLT_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (en && func == FN_SLT) |=> (status[ST_C] == ($past(a) >= $past(b)))); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(result) && $stable(status))); // R8
  AST_RSV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && func == FN_RSV) |=> ($stable(result) && $stable(status))); // R9

endmodule

bind asc_unit asc_unit_chk #(.WIDTH(WIDTH)) u_asc_unit_chk (.*);

// File: tb/asc_unit_bench.sv
module asc_unit_bench;

  localparam int W = 8;
  localparam int M = 1 << W;
  localparam int H = 1 << (W - 1);

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         en = 1'b0;
  logic [1:0]   func = 2'b00;
  logic         signed_op = 1'b0;
  logic [W-1:0] a = '0;
  logic [W-1:0] b = '0;
  logic [W-1:0] result;
  logic [3:0]   status;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  // pending expectation from the previously applied vector
  bit         pend = 1'b0;
  int         p_fn;
  int         p_r;
  logic [3:0] p_st;

  always #5 clk = ~clk;

  asc_unit #(.WIDTH(W), .GW(4)) u_asc_unit (
    .clk(clk), .rst_n(rst_n), .en(en), .func(func), .signed_op(signed_op),
    .a(a), .b(b), .result(result), .status(status)
  );

  function automatic int sval(input int v);
    return (v >= H) ? v - M : v;
  endfunction

  function automatic bit out_of_range(input int v);
    return (v > H - 1) || (v < -H);
  endfunction

  // status layout: bit3 C, bit2 V, bit1 Z, bit0 N
  task automatic model(input int fn, input int sm, input int av, input int bv,
                       output int r, output logic [3:0] st);
    int sa;
    int sb;
    bit c;
    bit v;
    sa = sval(av);
    sb = sval(bv);
    if (fn == 0) begin
      r = (av + bv) % M;
      c = (av + bv) >= M;
      v = (sm != 0) && out_of_range(sa + sb);
    end else begin
      c = av >= bv;
      v = (sm != 0) && out_of_range(sa - sb);
      if (fn == 1) r = (av - bv + M) % M;
      else         r = ((sm != 0) ? (sa < sb) : (av < bv)) ? 1 : 0;
    end
    st = {c, v, (r == 0), (r >= H)};
  endtask

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_pending();
    string rtag;
    if (pend) begin
      case (p_fn)
        0:       rtag = "R1";
        1:       rtag = "R2";
        default: rtag = (signed_op) ? "R5" : "R6";
      endcase
      check(rtag, int'(result), p_r);
      check("R3", int'(status[2]), int'(p_st[2]));
      check((p_fn == 2) ? "R7" : "R4", int'({status[3], status[1:0]}),
            int'({p_st[3], p_st[1:0]}));
      pend = 1'b0;
    end
  endtask

  // one vector per cycle: check the previous one, then drive the next
  task automatic step(input int fn, input int sm, input int av, input int bv);
    @(negedge clk);
    check_pending();
    en = 1'b1;
    func = 2'(fn);
    signed_op = (sm != 0);
    a = W'(av);
    b = W'(bv);
    model(fn, sm, av, bv, p_r, p_st);
    p_fn = fn;
    pend = 1'b1;
  endtask

  task automatic flush();
    @(negedge clk);
    check_pending();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R10: reset values
    repeat (3) @(negedge clk);
    check("R10", int'(result), 0);
    check("R10", int'(status), 4'b0010);
    rst_n = 1'b1;

    // directed corners (R1 R2 R3 R5 R6)
    step(0, 1, 8'h7f, 8'h01);
    step(0, 0, 8'hff, 8'h01);
    step(1, 1, 8'h80, 8'h01);
    step(1, 0, 8'h00, 8'h00);
    step(2, 1, 8'h80, 8'h7f);
    step(2, 0, 8'h80, 8'h7f);
    step(2, 1, 8'h05, 8'h05);
    flush();

    // near-exhaustive sweep
    for (int sm = 0; sm < 2; sm++)
      for (int fn = 0; fn < 3; fn++)
        for (int av = 0; av < M; av += 3)
          for (int bv = 0; bv < M; bv++)
            step(fn, sm, av, bv);
    flush();

    // R8: enable low holds outputs
    step(0, 0, 8'h05, 8'h07);
    flush();
    en = 1'b0;
    func = 2'b01;
    a = 8'h00;
    b = 8'h33;
    repeat (3) @(negedge clk);
    check("R8", int'(result), 8'h0c);
    check("R8", int'(status), 4'b0000);

    // R9: reserved code with enable high holds outputs
    en = 1'b1;
    func = 2'b11;
    a = 8'h80;
    b = 8'h80;
    repeat (3) @(negedge clk);
    check("R9", int'(result), 8'h0c);
    check("R9", int'(status), 4'b0000);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule